// File: doc/BRIEF.md
# Write-Only I2C Voltage-Code Register Slave

This block is a receive-only I2C target that lets a host set a 6-bit output-voltage code. It samples the bus lines on the system clock through synchronizers. It finds START and STOP conditions, checks the device address byte, and takes a word-address byte that loads an internal pointer. Each data byte that follows is written to the location the pointer holds, and the pointer then steps to the next location.

Only location 00h exists. A value n from 0 to 40 written there selects an output of 1.5 V + n x 0.1 V. The value appears on the code output together with a one-cycle update strobe. All other locations, and all out-of-range values, are acknowledged and then dropped.

The block never sends data and never stretches the clock. Its only drive onto the bus is an open-drain pull-down on SDA during acknowledge slots. The system clock must run at least 8x the bus bit rate.

Top module: `vreg_i2c_slave`

## Requirements
- R1: After reset the SDA pull-down is off, the code output holds the reset value (0) and the strobe is low. SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP; a STOP returns the slave to idle.
- R2: The first byte after a START is compared with 8'h10 (7-bit address 08h, R/W bit 0 = write, sent MSB first). A match is acknowledged by holding SDA low through the high phase of the ninth clock.
- R3: An address byte with another value, including 8'h11 (R/W = 1), gets no acknowledge. The slave then neither acknowledges nor stores anything until the next START.
- R4: Once addressed, the slave acknowledges the word-address byte and every data byte. It pulls SDA low only in acknowledge slots, and only after an SCL falling edge.
- R5: A data byte written at word address 00h whose value is 0 to 40 is stored and driven on the 6-bit code output.
- R6: A data byte above 40 (this covers any byte with bit 7 or bit 6 set) is acknowledged, but the stored code stays unchanged and no strobe is issued.
- R7: The update strobe is high for exactly one clock for each stored code, in the same cycle the new code first appears on the output. It never fires otherwise.
- R8: After each data byte the word pointer increments by one, wrapping from FFh to 00h. A burst starting at 00h therefore sends its second byte to 01h, and a burst starting at FFh stores its second byte at 00h.
- R9: A data byte written at any word address other than 00h is acknowledged and discarded.
- R10: A START that arrives in the middle of a byte abandons that byte and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the bus bit rate |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen at the pad (asynchronous) |
| sda_oe_o | output | 1 | High to pull SDA low (open-drain acknowledge) |
| vcode_o | output | 6 | Stored voltage code, 0 to 40 |
| vcode_stb_o | output | 1 | One-cycle pulse when a new code is stored |

## Verification
Several rules hold on every cycle and are checked there:
- the stored code never leaves 0..40;
- the code only changes together with a strobe, and the strobe is a single-cycle pulse caused by a data-byte event;
- the SDA pull-down is only raised after an SCL falling edge and only while the slave is addressed;
- the ignore state stays silent;
- every START re-arms address reception.

Other behaviour depends on whole bus transfers, and only the bench scenarios can show it: which address values are acknowledged, that out-of-range bytes and other locations are dropped, that the pointer steps and wraps within a burst, and that a START in mid-byte recovers.

// File: rtl/vreg_i2c_pkg.sv
package vreg_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WADDR,
    ST_DATA,
    ST_IGNORE
  } rx_state_e;

  // One received byte handed from the bit engine to the register side.
  typedef struct packed {
    logic       waddr_wr;
    logic       data_wr;
    logic [7:0] byte_val;
  } rx_evt_t;

endpackage

// File: rtl/vreg_i2c_sync.sv
module vreg_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_q, sda_q;
  logic              scl_s, sda_s;

  // Synchronizer chains; an idle bus reads high.
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s      = scl_ff[LAST];
  assign sda_s      = sda_ff[LAST];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/vreg_i2c_rx.sv
module vreg_i2c_rx
  import vreg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h08
) (
  input  logic    clk_i,
  input  logic    rst_n,
  input  logic    sda_i,
  input  logic    scl_rise_i,
  input  logic    scl_fall_i,
  input  logic    start_i,
  input  logic    stop_i,
  output logic    ack_o,
  output rx_evt_t evt_o
);

  localparam int          BITS    = 8;
  localparam int          CNT_W   = $clog2(BITS + 1);
  localparam logic [7:0]  WR_ADDR = {DEV_ADDR, 1'b0};
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BITS);

  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] bitcnt_q, bitcnt_d;
  logic [7:0]       shift_q, shift_d;
  logic             ack_q, ack_d;
  rx_evt_t          evt_q, evt_d;
  logic             active;

  assign active = (state_q == ST_ADDR) || (state_q == ST_WADDR) || (state_q == ST_DATA);

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    shift_d  = shift_q;
    ack_d    = ack_q;
    evt_d    = '0;
    if (start_i) begin
      state_d  = ST_ADDR;
      bitcnt_d = '0;
      ack_d    = 1'b0;
    end else if (stop_i) begin
      state_d  = ST_IDLE;
      bitcnt_d = '0;
      ack_d    = 1'b0;
    end else if (active) begin
      if (scl_rise_i && !ack_q && (bitcnt_q < FULL)) begin
        shift_d  = {shift_q[6:0], sda_i};
        bitcnt_d = bitcnt_q + 1'b1;
      end
      if (scl_fall_i) begin
        if (ack_q) begin
          // End of the acknowledge clock: release SDA, move on.
          ack_d    = 1'b0;
          bitcnt_d = '0;
          case (state_q)
            ST_ADDR:  state_d = ST_WADDR;
            ST_WADDR: state_d = ST_DATA;
            default:  state_d = state_q;
          endcase
        end else if (bitcnt_q == FULL) begin
          case (state_q)
            ST_ADDR: begin
              if (shift_q == WR_ADDR) ack_d = 1'b1;
              else                    state_d = ST_IGNORE;
            end
            ST_WADDR: begin
              ack_d          = 1'b1;
              evt_d.waddr_wr = 1'b1;
              evt_d.byte_val = shift_q;
            end
            ST_DATA: begin
              ack_d          = 1'b1;
              evt_d.data_wr  = 1'b1;
              evt_d.byte_val = shift_q;
            end
            default: state_d = state_q;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shift_q  <= '0;
      ack_q    <= 1'b0;
      evt_q    <= '0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      shift_q  <= shift_d;
      ack_q    <= ack_d;
      evt_q    <= evt_d;
    end
  end

  assign ack_o = ack_q;
  assign evt_o = evt_q;

  AST_ACK_WHEN_ADDRESSED: assert property (@(posedge clk_i) disable iff (!rst_n)
    ack_q |-> (state_q == ST_ADDR || state_q == ST_WADDR || state_q == ST_DATA)); // R4
  AST_ACK_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(ack_q) |-> $past(scl_fall_i)); // R4
  AST_IGNORE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> (!ack_q && !evt_q.data_wr && !evt_q.waddr_wr)); // R3
  AST_START_REARM: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_i |=> (state_q == ST_ADDR && !ack_q && bitcnt_q == '0)); // R10

endmodule

// File: rtl/vreg_i2c_regs.sv
module vreg_i2c_regs
  import vreg_i2c_pkg::*;
#(
  parameter int              CODE_W   = 6,
  parameter int              CODE_MAX = 40,
  parameter logic [CODE_W-1:0] CODE_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  rx_evt_t           evt_i,
  output logic [CODE_W-1:0] code_o,
  output logic              stb_o
);

  localparam int         PTR_W    = 8;
  localparam logic [PTR_W-1:0] CODE_LOC = '0;
  localparam logic [7:0] LIMIT    = 8'(CODE_MAX);

  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              ptr_en;
  logic [CODE_W-1:0] code_q, code_d;
  logic              code_en;
  logic              stb_q, stb_d;

  always_comb begin
    ptr_en  = evt_i.waddr_wr | evt_i.data_wr;
    ptr_d   = evt_i.waddr_wr ? evt_i.byte_val : ptr_q + 1'b1;
    code_en = evt_i.data_wr && (ptr_q == CODE_LOC) && (evt_i.byte_val <= LIMIT);
    code_d  = evt_i.byte_val[CODE_W-1:0];
    stb_d   = code_en;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      code_q <= CODE_RST;
      stb_q  <= 1'b0;
    end else begin
      if (ptr_en)  ptr_q  <= ptr_d;
      if (code_en) code_q <= code_d;
      stb_q <= stb_d;
    end
  end

  assign code_o = code_q;
  assign stb_o  = stb_q;

  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n)
    int'(code_q) <= CODE_MAX); // R5
  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    !stb_q |-> $stable(code_q)); // R6
  AST_STB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_n)
    stb_q |=> !stb_q); // R7
  AST_STB_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_n)
    stb_q |-> $past(evt_i.data_wr)); // R7

endmodule

// File: rtl/vreg_i2c_slave.sv
module vreg_i2c_slave
  import vreg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h08,
  parameter int         CODE_W      = 6,
  parameter int         CODE_MAX    = 40,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [CODE_W-1:0] vcode_o,
  output logic              vcode_stb_o
);

  logic [1:0] rst_ff;
  logic       rst_n;
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  rx_evt_t    evt;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_ff <= 2'b00;
    else         rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_n = rst_ff[1];

  vreg_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  vreg_i2c_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .ack_o      (sda_oe_o),
    .evt_o      (evt)
  );

  vreg_i2c_regs #(.CODE_W(CODE_W), .CODE_MAX(CODE_MAX), .CODE_RST('0)) u_regs (
    .clk_i  (clk_i),
    .rst_n  (rst_n),
    .evt_i  (evt),
    .code_o (vcode_o),
    .stb_o  (vcode_stb_o)
  );

endmodule

// File: tb/tb_vreg_i2c_slave.sv
module tb_vreg_i2c_slave;

  localparam int Q = 8;  // system clocks per quarter bit

  logic       clk, rst_n, scl, sda_drv;
  wire        sda_line;
  logic       sda_oe;
  logic [5:0] vcode;
  logic       vstb;
  int         checks, fails;
  int         exp_q[$];

  assign sda_line = sda_drv & ~sda_oe;

  vreg_i2c_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .vcode_o(vcode), .vcode_stb_o(vstb)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wq(Q);
    scl = 1'b1;     wq(Q);
    sda_drv = 1'b0; wq(Q);
    scl = 1'b0;     wq(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wq(Q);
    scl = 1'b1;     wq(Q);
    sda_drv = 1'b1; wq(2*Q);
  endtask

  task automatic send_bit(input bit b);
    sda_drv = b; wq(Q);
    scl = 1'b1;  wq(2*Q);
    scl = 1'b0;  wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_drv = 1'b1; wq(Q);
    scl = 1'b1;     wq(Q);
    check((sda_line == 1'b0) == exp_ack, req, int'(!sda_line), int'(exp_ack));
    wq(Q);
    scl = 1'b0;     wq(Q);
  endtask

  // Driver: one write frame; pushes the expected stored code if any.
  task automatic write_frame(input logic [7:0] waddr, input logic [7:0] data);
    bus_start();
    send_byte(8'h10, 1'b1, "R2 addr ack");
    send_byte(waddr, 1'b1, "R4 waddr ack");
    if (waddr == 8'h00 && data <= 8'd40) exp_q.push_back(int'(data));
    send_byte(data, 1'b1, "R4 data ack");
    bus_stop();
  endtask

  // Monitor: every strobe must match the oldest expected code.
  always @(negedge clk) begin
    if (rst_n && vstb) begin
      if (exp_q.size() == 0) check(1'b0, "R7 unexpected strobe", int'(vcode), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(int'(vcode) == e, "R5 stored code", int'(vcode), e);
      end
    end
  end

  initial begin
    #1_000_000;
    check(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    scl = 1'b1; sda_drv = 1'b1; rst_n = 1'b0;
    wq(5);
    // R1 reset state
    check(sda_oe == 1'b0, "R1 oe at reset", int'(sda_oe), 0);
    check(vcode == 6'd0, "R1 code at reset", int'(vcode), 0);
    check(vstb == 1'b0, "R1 strobe at reset", int'(vstb), 0);
    rst_n = 1'b1; wq(5);

    // R5 plain store, boundaries
    write_frame(8'h00, 8'd20);
    check(vcode == 6'd20, "R5 code 20", int'(vcode), 20);
    write_frame(8'h00, 8'd40);
    check(vcode == 6'd40, "R5 code 40", int'(vcode), 40);
    write_frame(8'h00, 8'd0);
    check(vcode == 6'd0, "R5 code 0", int'(vcode), 0);
    write_frame(8'h00, 8'd33);

    // R6 out of range, incl. bits 7:6 set
    write_frame(8'h00, 8'd41);
    check(vcode == 6'd33, "R6 code 41 dropped", int'(vcode), 33);
    write_frame(8'h00, 8'hC5);
    check(vcode == 6'd33, "R6 code C5 dropped", int'(vcode), 33);

    // R9 other location
    write_frame(8'h05, 8'd3);
    check(vcode == 6'd33, "R9 loc 05 dropped", int'(vcode), 33);

    // R8 burst from 00h: second byte lands at 01h
    bus_start();
    send_byte(8'h10, 1'b1, "R2 addr ack");
    send_byte(8'h00, 1'b1, "R4 waddr ack");
    exp_q.push_back(7);
    send_byte(8'd7, 1'b1, "R8 burst byte0 ack");
    send_byte(8'd9, 1'b1, "R8 burst byte1 ack");
    bus_stop();
    check(vcode == 6'd7, "R8 burst second byte to 01h", int'(vcode), 7);

    // R8 wrap FFh -> 00h
    bus_start();
    send_byte(8'h10, 1'b1, "R2 addr ack");
    send_byte(8'hFF, 1'b1, "R4 waddr ack");
    send_byte(8'd11, 1'b1, "R8 wrap byte0 ack");
    exp_q.push_back(12);
    send_byte(8'd12, 1'b1, "R8 wrap byte1 ack");
    bus_stop();
    check(vcode == 6'd12, "R8 wrap stores at 00h", int'(vcode), 12);

    // R3 read bit set: no ack, rest ignored
    bus_start();
    send_byte(8'h11, 1'b0, "R3 read addr nack");
    send_byte(8'h00, 1'b0, "R3 ignored byte nack");
    send_byte(8'd30, 1'b0, "R3 ignored byte nack");
    bus_stop();
    check(vcode == 6'd12, "R3 ignored write", int'(vcode), 12);

    // R3 wrong address
    bus_start();
    send_byte(8'h20, 1'b0, "R3 wrong addr nack");
    send_byte(8'h00, 1'b0, "R3 ignored byte nack");
    bus_stop();

    // R10 START in mid-byte, then repeated START without STOP (R1)
    bus_start();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_byte(8'h10, 1'b1, "R10 addr after restart ack");
    send_byte(8'h00, 1'b1, "R10 waddr ack");
    exp_q.push_back(25);
    send_byte(8'd25, 1'b1, "R10 data ack");
    bus_start();
    send_byte(8'h10, 1'b1, "R1 repeated start addr ack");
    send_byte(8'h00, 1'b1, "R1 waddr ack");
    exp_q.push_back(26);
    send_byte(8'd26, 1'b1, "R1 data ack");
    bus_stop();
    check(vcode == 6'd26, "R10 store after restart", int'(vcode), 26);

    // R1 after STOP the pull-down is released
    wq(4*Q);
    check(sda_oe == 1'b0, "R1 oe idle after stop", int'(sda_oe), 0);
    check(exp_q.size() == 0, "R7 all expected strobes seen", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule